// File: doc/BRIEF.md
# Masked Single-to-Bfloat16 Lane Narrower

This block takes a vector of single-precision values and narrows each selected 32-bit lane to bfloat16. The narrowed value stays in its own lane: it occupies the lower half, and the upper half is cleared. A byte-granular predicate selects the lanes. Lanes that are not selected pass the matching lane of an old destination vector through unchanged, so the output is the old destination with the selected lanes overwritten.

The narrowing is computed combinationally from a source vector, the old destination vector, the predicate and run-time controls. The controls are a two-bit rounding mode, a flush-to-zero bit and a default-NaN bit. The block registers the result vector and a five-bit exception summary. An output valid strobe follows the input valid strobe one cycle later, and the registers hold their contents while the input valid is low.

The vector width `VL` is a parameter and must be a multiple of 32. A surrounding execution pipeline uses the block as one stage: it supplies operands from its own register file and consumes the flags.

Top module: `bf16_narrow_conv`

## Requirements
- R1: Lane e (bits 32e+31..32e) is selected exactly when predicate bit 4e is 1. Predicate bits 4e+1..4e+3 have no effect on the lane or on the flags.
- R2: For an unselected lane, all 32 output bits equal the same lane of `old_dst`.
- R3: For a selected lane, bits 15..0 hold the bfloat16 result and bits 31..16 are zero. The bfloat16 layout is sign at bit 15, exponent at 14..7 and fraction at 6..0.
- R4: When no lane is selected, the output equals `old_dst` and all flags are zero.
- R5: `rnd_mode` encodes 0 = nearest with ties to even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero. Rounding acts on the 16 discarded fraction bits.
- R6: A rounding carry out of the fraction increments the exponent. A result that reaches exponent 255 is infinity and raises both overflow and inexact. Inputs that are already infinite convert exactly and raise no flag.
- R7: A NaN input yields sign, exponent 255, bit 6 set and fraction bits 21..16 copied to bits 5..0. It raises invalid only if input fraction bit 22 is 0. With `dflt_nan` = 1, the result is 0x7FC0.
- R8: With `ftz` = 1, a subnormal input yields a signed zero and raises input-denormal only. With `ftz` = 0, a subnormal input is rounded normally and raises underflow when the rounding is inexact.
- R9: The `flags` bit positions are: 0 invalid, 1 overflow, 2 underflow, 3 inexact, 4 input-denormal. Each bit is the OR of that condition over the selected lanes only.
- R10: `out_valid` equals `in_valid` one cycle earlier. While `in_valid` is 0, `res_vec` and `flags` keep their values.
- R11: While reset is asserted and after its release, `out_valid`, `res_vec` and `flags` are zero until the first valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| src_vec | input | VL | Single-precision source lanes |
| old_dst | input | VL | Prior destination contents |
| pred | input | VL/8 | Byte predicate, bit 4e selects lane e |
| rnd_mode | input | 2 | Rounding mode (R5 encoding) |
| ftz | input | 1 | Flush subnormal inputs to zero |
| dflt_nan | input | 1 | Replace NaN results with 0x7FC0 |
| out_valid | output | 1 | Registered result present |
| res_vec | output | VL | Merged result vector |
| flags | output | 5 | Exception summary (R9 layout) |

## Verification
Two things can happen in the same cycle: exceptional values raise flags, and the predicate masks lanes, so flag accumulation and lane masking meet in one operation. The bench provokes this with vectors that put a signalling NaN or a subnormal in an unselected lane, next to an overflowing or inexact value in a selected lane. It also drives predicates where only the upper three bits of a lane's nibble are set. A correct result shows only the selected lanes' flags, with unselected lanes copied bit for bit from the old destination. The behavioural model checks this on every operation, both in the directed cases and in the randomized mixes.

// File: rtl/bfcv_pkg.sv
package bfcv_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_POS_INF   = 2'd1,
    RND_NEG_INF   = 2'd2,
    RND_ZERO      = 2'd3
  } rnd_mode_e;

  // bit0 invalid, bit1 overflow, bit2 underflow, bit3 inexact, bit4 in_denorm
  typedef struct packed {
    logic in_denorm;
    logic inexact;
    logic underflow;
    logic overflow;
    logic invalid;
  } exc_flags_t;

  localparam int unsigned FP_W   = 32;
  localparam int unsigned BF_W   = 16;
  localparam int unsigned FLAG_W = 5;

endpackage

// File: rtl/bfcv_lane_cvt.sv
module bfcv_lane_cvt
  import bfcv_pkg::*;
(
  input  logic [FP_W-1:0] fp_in,
  input  rnd_mode_e       rmode,
  input  logic            ftz,
  input  logic            dflt_nan,
  output logic [BF_W-1:0] bf_out,
  output exc_flags_t      exc
);

  logic        sgn;
  logic [7:0]  expo;
  logic [22:0] frac;
  logic [14:0] kept;
  logic [15:0] drop;
  logic        is_nan, is_inf, is_sub;
  logic        guard, stky, lost, inc;
  logic [15:0] sum;

  assign sgn  = fp_in[31];
  assign expo = fp_in[30:23];
  assign frac = fp_in[22:0];
  assign kept = fp_in[30:16];
  assign drop = fp_in[15:0];

  assign is_nan = (&expo) & (|frac);
  assign is_inf = (&expo) & ~(|frac);
  assign is_sub = ~(|expo) & (|frac);

  assign guard = drop[15];
  assign stky  = |drop[14:0];
  assign lost  = |drop;

  always_comb begin
    unique case (rmode)
      RND_NEAR_EVEN: inc = guard & (stky | kept[0]);
      RND_POS_INF:   inc = ~sgn & lost;
      RND_NEG_INF:   inc = sgn & lost;
      default:       inc = 1'b0;
    endcase
  end

  assign sum = {1'b0, kept} + {15'd0, inc};

  always_comb begin
    bf_out = {sgn, sum[14:0]};
    exc    = '0;
    if (is_nan) begin
      bf_out      = dflt_nan ? 16'h7FC0 : {sgn, 8'hFF, 1'b1, frac[21:16]};
      exc.invalid = ~frac[22];
    end else if (is_inf) begin
      bf_out = {sgn, 8'hFF, 7'd0};
    end else if (is_sub && ftz) begin
      bf_out        = {sgn, 15'd0};
      exc.in_denorm = 1'b1;
    end else begin
      exc.inexact   = lost;
      exc.overflow  = &sum[14:7];
      exc.underflow = is_sub & lost;
    end
  end

endmodule

// File: rtl/bfcv_lane_merge.sv
module bfcv_lane_merge
  import bfcv_pkg::*;
(
  input  logic            lane_en,
  input  logic [BF_W-1:0] cvt_val,
  input  exc_flags_t      cvt_exc,
  input  logic [FP_W-1:0] old_lane,
  output logic [FP_W-1:0] lane_out,
  output exc_flags_t      lane_exc
);

  always_comb begin
    if (lane_en) begin
      lane_out = {{(FP_W-BF_W){1'b0}}, cvt_val};
      lane_exc = cvt_exc;
    end else begin
      lane_out = old_lane;
      lane_exc = '0;
    end
  end

endmodule

// File: rtl/bf16_narrow_conv.sv
module bf16_narrow_conv
  import bfcv_pkg::*;
#(
  parameter int unsigned VL = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VL-1:0]   src_vec,
  input  logic [VL-1:0]   old_dst,
  input  logic [VL/8-1:0] pred,
  input  logic [1:0]      rnd_mode,
  input  logic            ftz,
  input  logic            dflt_nan,
  output logic            out_valid,
  output logic [VL-1:0]   res_vec,
  output logic [4:0]      flags
);

  localparam int unsigned NLANE = VL / FP_W;
  localparam int unsigned BPL   = FP_W / 8;

  logic [NLANE-1:0]  lane_act;
  logic              any_act;
  logic [VL-1:0]     op_src;
  logic [VL-1:0]     merged;
  exc_flags_t        lane_exc [NLANE];
  exc_flags_t        exc_or;
  rnd_mode_e         rmode;

  logic              vld_d, vld_q;
  logic [VL-1:0]     res_d, res_q;
  logic [4:0]        flg_d, flg_q;

  assign rmode = rnd_mode_e'(rnd_mode);

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      logic [BF_W-1:0] cv;
      exc_flags_t      ce;

      assign lane_act[g] = pred[BPL*g];

      bfcv_lane_cvt u_cvt (
        .fp_in    (op_src[FP_W*g +: FP_W]),
        .rmode    (rmode),
        .ftz      (ftz),
        .dflt_nan (dflt_nan),
        .bf_out   (cv),
        .exc      (ce)
      );

      bfcv_lane_merge u_mrg (
        .lane_en  (lane_act[g]),
        .cvt_val  (cv),
        .cvt_exc  (ce),
        .old_lane (old_dst[FP_W*g +: FP_W]),
        .lane_out (merged[FP_W*g +: FP_W]),
        .lane_exc (lane_exc[g])
      );

      assert_inactive_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(pred[BPL*g]))
          |-> (res_vec[FP_W*g +: FP_W] == $past(old_dst[FP_W*g +: FP_W])));

      assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(pred[BPL*g]))
          |-> (res_vec[FP_W*g+BF_W +: (FP_W-BF_W)] == '0));
    end
  endgenerate

  assign any_act = |lane_act;
  assign op_src  = any_act ? src_vec : '0;

  always_comb begin
    exc_or = '0;
    for (int i = 0; i < NLANE; i++) exc_or = exc_or | lane_exc[i];
  end

  // next-state
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    flg_d = flg_q;
    if (in_valid) begin
      res_d = merged;
      flg_d = exc_or;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid = vld_q;
  assign res_vec   = res_q;
  assign flags     = flg_q;

  assert_valid_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(res_vec) && $stable(flags)));

  assert_no_active_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && !$past(any_act))
      |-> (flags == 5'd0 && res_vec == $past(old_dst)));

  assert_ovf_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[1]) |-> flags[3]);

endmodule

// File: tb/sim_bf16_narrow_conv.sv
`timescale 1ns/1ps
module sim_bf16_narrow_conv;

  localparam int VL = 128;
  localparam int PW = VL / 8;
  localparam int NL = VL / 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [VL-1:0] src_vec, old_dst;
  logic [PW-1:0] pred;
  logic [1:0]    rnd_mode;
  logic          ftz, dflt_nan;
  logic          out_valid;
  logic [VL-1:0] res_vec;
  logic [4:0]    flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [VL-1:0] exp_res;
  logic [4:0]    exp_flg;

  always #2 clk = ~clk;

  bf16_narrow_conv #(.VL(VL)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .old_dst(old_dst), .pred(pred), .rnd_mode(rnd_mode), .ftz(ftz),
    .dflt_nan(dflt_nan), .out_valid(out_valid), .res_vec(res_vec), .flags(flags)
  );

  // Behavioural model of one lane: returns {flags, bf16}
  function automatic logic [20:0] model_lane(input logic [31:0] x, input int rm,
                                             input bit fz, input bit dn);
    int unsigned mag, q, rem;
    bit          neg, up;
    logic [4:0]  f;
    logic [15:0] r;
    neg = x[31];
    mag = {1'b0, x[30:0]};
    f   = '0;
    if (mag > 32'h7F80_0000) begin
      r = dn ? 16'h7FC0 : ({neg, x[30:16]} | 16'h0040);
      if (!x[22]) f[0] = 1'b1;
    end else if (mag == 32'h7F80_0000) begin
      r = {neg, 15'h7F80};
    end else if (mag != 0 && mag < 32'h0080_0000 && fz) begin
      r = {neg, 15'h0};
      f[4] = 1'b1;
    end else begin
      q   = mag >> 16;
      rem = mag & 32'hFFFF;
      case (rm)
        0: up = (rem > 32'h8000) || (rem == 32'h8000 && (q % 2) == 1);
        1: up = !neg && rem != 0;
        2: up = neg && rem != 0;
        default: up = 1'b0;
      endcase
      if (up) q = q + 1;
      r = {neg, 15'(q)};
      if (rem != 0) f[3] = 1'b1;
      if (q >= 32'h7F80) f[1] = 1'b1;
      if (mag < 32'h0080_0000 && rem != 0) f[2] = 1'b1;
    end
    return {f, r};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [VL-1:0] act, input logic [VL-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Drives at the current (negedge) time, checks at the next negedge.
  task automatic run_op(input logic [VL-1:0] s, input logic [VL-1:0] o,
                        input logic [PW-1:0] p, input int rm, input bit fz,
                        input bit dn, input bit v, input string tag);
    logic [20:0] lr;
    in_valid = v; src_vec = s; old_dst = o; pred = p;
    rnd_mode = 2'(rm); ftz = fz; dflt_nan = dn;
    if (v) begin
      exp_flg = '0;
      for (int i = 0; i < NL; i++) begin
        if (p[4*i]) begin
          lr = model_lane(s[32*i +: 32], rm, fz, dn);
          exp_res[32*i +: 32] = {16'h0, lr[15:0]};
          exp_flg = exp_flg | lr[20:16];
        end else begin
          exp_res[32*i +: 32] = o[32*i +: 32];
        end
      end
    end
    @(negedge clk);
    check(out_valid == v, tag, "valid", VL'(out_valid), VL'(v));
    check(res_vec == exp_res, tag, "result", res_vec, exp_res);
    check(flags == exp_flg, tag, "flags", VL'(flags), VL'(exp_flg));
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 9))
      0: return 32'h7F7F_FFFF ^ {$urandom_range(0, 1), 31'h0};
      1: return {$urandom_range(0, 1) == 1, 8'hFF, 23'($urandom)};
      2: return {$urandom_range(0, 1) == 1, 8'h00, 23'($urandom)};
      3: return {$urandom_range(0, 1) == 1, 31'h7F80_0000};
      4: return {16'($urandom), 16'h8000};
      5: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  logic [VL-1:0] od;

  initial begin
    rst_n = 1'b0; in_valid = 0; src_vec = '0; old_dst = '0; pred = '0;
    rnd_mode = 0; ftz = 0; dflt_nan = 0;
    exp_res = '0; exp_flg = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && res_vec == '0 && flags == 0, "R11", "in reset",
          res_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && res_vec == '0 && flags == 0, "R11", "after release",
          res_vec, '0);

    od = {4{32'hDEAD_BEEF}};
    // R3 R5: exact, tie-even down, tie-odd up, above tie
    run_op({32'h3F80_8001, 32'h3F81_8000, 32'h3F80_8000, 32'h3F80_0000}, od,
           16'h1111, 0, 0, 0, 1, "R5_nearest");
    run_op({32'hBF80_0001, 32'h3F80_0001, 32'hBF80_0001, 32'h3F80_0001}, od,
           16'h1111, 1, 0, 0, 1, "R5_pos_inf");
    run_op({32'hBF80_0001, 32'h3F80_0001, 32'hBF80_0001, 32'h3F80_0001}, od,
           16'h1111, 2, 0, 0, 1, "R5_neg_inf");
    run_op({32'hBF80_FFFF, 32'h3F80_FFFF, 32'hBF80_8000, 32'h3F80_8000}, od,
           16'h1111, 3, 0, 0, 1, "R5_zero");
    // R6: carry into exponent, overflow to inf, inf input
    run_op({32'hFF80_0000, 32'h7F80_0000, 32'h3FFF_FFFF, 32'h7F7F_FFFF}, od,
           16'h1111, 0, 0, 0, 1, "R6_overflow");
    run_op({32'h0, 32'h0, 32'h0, 32'h7F7F_FFFF}, od, 16'h0001, 3, 0, 0, 1, "R6_rz_max");
    run_op({32'h3F80_0000, 32'h7F80_0000, 32'h3FFF_FFFF, 32'h7F7F_FFFF}, od,
           16'h1110, 0, 0, 0, 1, "R6_inf_only");
    // R7: NaNs
    run_op({32'h7FC0_0001, 32'hFFA1_2345, 32'h7FE5_0000, 32'h7FA1_2345}, od,
           16'h1111, 0, 0, 0, 1, "R7_nan_payload");
    run_op({32'h7FC0_0001, 32'hFFA1_2345, 32'h7FE5_0000, 32'h7FA1_2345}, od,
           16'h1111, 0, 0, 1, 1, "R7_default_nan");
    // R8: subnormals
    run_op({32'h0000_0000, 32'h8001_0000, 32'h807F_FFFF, 32'h0001_2345}, od,
           16'h1111, 0, 1, 0, 1, "R8_ftz");
    run_op({32'h0000_0000, 32'h8001_0000, 32'h807F_FFFF, 32'h0001_2345}, od,
           16'h1111, 0, 0, 0, 1, "R8_no_ftz");
    // R1 R2 R4 R9: masking and flags from selected lanes only
    run_op({32'h7FA1_2345, 32'h0001_2345, 32'h7F7F_FFFF, 32'h7FA0_0000}, od,
           16'hEEEE, 0, 1, 0, 1, "R1_upper_bits_only");
    run_op({32'h7FA1_2345, 32'h0001_2345, 32'h7F7F_FFFF, 32'h7FA0_0000}, od,
           16'h0000, 0, 1, 0, 1, "R4_none_active");
    run_op({32'h7FA1_2345, 32'h0001_2345, 32'h7F7F_FFFF, 32'h3F80_0001}, od,
           16'h0013, 0, 1, 0, 1, "R9_masked_flags");
    run_op({32'h1234_5678, 32'h0001_2345, 32'h7F7F_FFFF, 32'h7FA0_0000},
           {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444},
           16'h1F0E, 0, 1, 0, 1, "R2_keep_old");
    // R10: hold while idle
    run_op({4{32'h4049_0FDB}}, od, 16'hFFFF, 0, 0, 0, 1, "R10_load");
    run_op({4{32'h0000_0000}}, '0, 16'h0000, 3, 1, 1, 0, "R10_hold");
    run_op({4{32'hC000_0000}}, '0, 16'h0000, 3, 1, 1, 0, "R10_hold2");

    for (int k = 0; k < 400; k++) begin
      logic [VL-1:0] s, o;
      for (int i = 0; i < NL; i++) begin
        s[32*i +: 32] = pick_val();
        o[32*i +: 32] = $urandom;
      end
      run_op(s, o, 16'($urandom), $urandom_range(0, 3), $urandom_range(0, 1) == 1,
             $urandom_range(0, 1) == 1, $urandom_range(0, 4) != 0, "R9_random_mix");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule